// File: doc/BRIEF.md
# Ordered-Set Rate Shift Controller

This block moves a serial link between its full symbol rate and exactly one tenth of it without retraining and without a second PHY state machine. Both rates run from the same high-speed clock. A divide-by-ten counter produces a symbol enable that is either high in every cycle (full rate) or high once per counter cycle (low rate). The byte-wide encoder path stays clocked at all times, so it keeps its alignment across a change.

On the transmit side a shift request is latched. The controller then waits for the first idle symbol of an inter-packet gap and writes a four-symbol speed-change ordered set over the idle bytes. The set carries the direction and a countdown. Once the countdown has run out, the transmit divider changes rate at its next wrap. On the receive side the same set is decoded from the incoming stream, and the receive divider changes rate at the matching symbol. With a zero-latency loopback both ends change in the same cycle.

Transmit FSM states: T_IDLE, T_WAIT_GAP, T_SEND, T_COUNT, T_ARMED. Its transitions are:
- T_IDLE to T_WAIT_GAP when a pending request asks for the other speed. A request for the current speed is dropped.
- T_WAIT_GAP to T_SEND on the first idle symbol of a gap.
- T_SEND to T_COUNT after the fourth lane.
- T_COUNT to T_ARMED when the countdown symbols are used up.
- T_ARMED to T_IDLE at the divider wrap, where the speed flips.

Receive FSM states: R_HUNT, R_LANE1, R_LANE2, R_LANE3, R_COUNT, R_ARMED. Its transitions are:
- R_HUNT to R_LANE1 on the marker.
- R_LANE1 to R_LANE2 to R_LANE3 on valid lanes. Any bad lane returns the FSM to R_HUNT.
- R_LANE3 to R_COUNT on a countdown of at least 3.
- R_COUNT to R_ARMED when the countdown ends.
- R_ARMED to R_HUNT at the wrap.

Top module: `rate_shift_ctrl`

## Requirements
- R1: After reset both ends are at full rate: speed_is_low and rx_speed_is_low are 0, sym_en and rx_sym_en are 1 in every cycle, and tx_out equals tx_in.
- R2: At low rate sym_en is high in exactly one cycle of every ten, namely when the divider count (cycles since reset, modulo 10) is 0.
- R3: The speed flag changes only at the end of a cycle whose divider count is 9, so the new rate applies from count 0.
- R4: An ordered set begins only on an idle symbol (control flag 1, byte 0x07) that follows a non-idle symbol. It replaces the next four symbols. Every other symbol passes through unchanged.
- R5: The ordered set consists of four symbols. The first is the marker 0x9C with the control flag set. The other three carry the control flag clear. For a down shift they are 0x00, the down code (0x01), then n. For an up shift they are the up code (0x02), 0x00, then n.
- R6: The transmitter sends n = COUNT_N (at least 3). The speed flips at the first divider wrap that follows the n-th symbol after the set.
- R7: The receiver decodes the set from rx_in. In loopback, rx_speed_is_low and rx_sym_en equal speed_is_low and sym_en in every cycle.
- R8: On the receive side, a set with an unknown code pair or with n below 3 is ignored. So is a marker that arrives during a countdown. None of these changes the receive speed.
- R9: A shift request that arrives during a shift is held. It is acted on after the current shift completes, and a later request replaces an earlier held one.
- R10: A request for the speed already in use is dropped, and no ordered set is sent for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_req | input | 1 | One-cycle shift request |
| shift_dir | input | 1 | 1 = go to low rate, 0 = go to full rate |
| tx_in_data | input | 8 | Transmit byte from the encoder |
| tx_in_ctrl | input | 1 | Transmit control flag |
| tx_out_data | output | 8 | Transmit byte toward the line |
| tx_out_ctrl | output | 1 | Transmit control flag toward the line |
| rx_in_data | input | 8 | Received byte |
| rx_in_ctrl | input | 1 | Received control flag |
| speed_is_low | output | 1 | Transmit side at low rate |
| sym_en | output | 1 | Transmit symbol enable |
| rx_speed_is_low | output | 1 | Receive side at low rate |
| rx_sym_en | output | 1 | Receive symbol enable |

## Verification
Two events can fall in the same cycle: a fresh shift request, and the armed switch firing at a divider wrap or the start of a gap. The request must then be held or dropped, and must not disturb the switch in progress. Directed pulses place requests inside a running countdown. Random pulses at arbitrary cycles land on wraps and gap starts over thousands of cycles. A cycle-exact bench model judges each cycle. It derives the expected enable and speed from the divider phase and from the ordered sets seen on the line, and it counts the sets sent.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    typedef enum logic [2:0] {
        T_IDLE, T_WAIT_GAP, T_SEND, T_COUNT, T_ARMED
    } tx_state_t;

    typedef enum logic [2:0] {
        R_HUNT, R_LANE1, R_LANE2, R_LANE3, R_COUNT, R_ARMED
    } rx_state_t;

    localparam logic [7:0] MIN_COUNT = 8'd3;
endpackage

// File: rtl/rsc_divider.sv
module rsc_divider #(
    parameter int DIV_RATIO = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed_i,
    input  logic armed_low_i,
    output logic wrap_o,
    output logic sym_en_o,
    output logic low_o
);
    localparam int CW = $clog2(DIV_RATIO);
    localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

    logic [CW-1:0] cnt_q;
    logic          low_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            low_q <= 1'b0;
        end else begin
            cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
            if (armed_i && wrap_o) low_q <= armed_low_i;
        end
    end

    always_comb begin
        wrap_o   = (cnt_q == LAST);
        sym_en_o = !low_q || (cnt_q == '0);
        low_o    = low_q;
    end

    // R3
    speed_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_q != $past(low_q)) |-> $past(wrap_o));

    // R2
    low_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_q && $past(low_q) && sym_en_o) |-> !$past(sym_en_o));
endmodule

// File: rtl/rsc_tx_ctrl.sv
module rsc_tx_ctrl
    import rsc_pkg::*;
#(
    parameter logic [7:0] Q_CODE    = 8'h9C,
    parameter logic [7:0] IDLE_CODE = 8'h07,
    parameter logic [7:0] DOWN_CODE = 8'h01,
    parameter logic [7:0] UP_CODE   = 8'h02,
    parameter int         COUNT_N   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_en,
    input  logic       wrap,
    input  logic       cur_low,
    input  logic       shift_req,
    input  logic       shift_dir,
    input  logic [7:0] in_data,
    input  logic       in_ctrl,
    output logic [7:0] out_data,
    output logic       out_ctrl,
    output logic       armed,
    output logic       armed_low
);
    localparam logic [7:0] N_BYTE = 8'(COUNT_N);

    tx_state_t  state_q, state_d;
    logic       pend_v, pend_dir, dir_q, prev_busy;
    logic [1:0] lane_q, lane_sel;
    logic [7:0] cnt_q;
    logic       is_idle, gap_start, take, drop, emit;

    assign is_idle   = in_ctrl && (in_data == IDLE_CODE);
    assign gap_start = sym_en && is_idle && prev_busy;
    assign take      = (state_q == T_IDLE) && pend_v && (pend_dir != cur_low);
    assign drop      = (state_q == T_IDLE) && pend_v && (pend_dir == cur_low);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_IDLE:     if (take) state_d = T_WAIT_GAP;
            T_WAIT_GAP: if (gap_start) state_d = T_SEND;
            T_SEND:     if (sym_en && lane_q == 2'd3) state_d = T_COUNT;
            T_COUNT:    if (sym_en && cnt_q == 8'd1) state_d = T_ARMED;
            T_ARMED:    if (wrap) state_d = T_IDLE;
            default:    state_d = T_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= T_IDLE;
            pend_v    <= 1'b0;
            pend_dir  <= 1'b0;
            dir_q     <= 1'b0;
            prev_busy <= 1'b0;
            lane_q    <= 2'd0;
            cnt_q     <= 8'd0;
        end else begin
            state_q <= state_d;
            if (shift_req) begin
                pend_v   <= 1'b1;
                pend_dir <= shift_dir;
            end else if (take || drop) begin
                pend_v <= 1'b0;
            end
            if (take) dir_q <= pend_dir;
            if (sym_en) prev_busy <= !is_idle;
            if (state_q == T_WAIT_GAP && gap_start) lane_q <= 2'd1;
            else if (state_q == T_SEND && sym_en) lane_q <= lane_q + 2'd1;
            if (state_q == T_SEND && sym_en && lane_q == 2'd3) cnt_q <= N_BYTE;
            else if (state_q == T_COUNT && sym_en) cnt_q <= cnt_q - 8'd1;
        end
    end

    always_comb begin
        emit     = 1'b0;
        lane_sel = lane_q;
        out_data = in_data;
        out_ctrl = in_ctrl;
        if (state_q == T_WAIT_GAP && gap_start) begin
            emit     = 1'b1;
            lane_sel = 2'd0;
        end else if (state_q == T_SEND) begin
            emit = 1'b1;
        end
        if (emit) begin
            unique case (lane_sel)
                2'd0: begin out_data = Q_CODE; out_ctrl = 1'b1; end
                2'd1: begin out_data = dir_q ? 8'h00 : UP_CODE; out_ctrl = 1'b0; end
                2'd2: begin out_data = dir_q ? DOWN_CODE : 8'h00; out_ctrl = 1'b0; end
                default: begin out_data = N_BYTE; out_ctrl = 1'b0; end
            endcase
        end
        armed     = (state_q == T_ARMED);
        armed_low = dir_q;
    end

    // R4
    os_in_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ctrl && out_data == Q_CODE && !(in_ctrl && in_data == Q_CODE))
        |-> (in_ctrl && in_data == IDLE_CODE));

    // R9
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_req && state_q != T_IDLE) |=> pend_v);

    // R10
    drop_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_IDLE && pend_v && pend_dir == cur_low && !shift_req)
        |=> (state_q == T_IDLE && !pend_v));
endmodule

// File: rtl/rsc_rx_ctrl.sv
module rsc_rx_ctrl
    import rsc_pkg::*;
#(
    parameter logic [7:0] Q_CODE    = 8'h9C,
    parameter logic [7:0] DOWN_CODE = 8'h01,
    parameter logic [7:0] UP_CODE   = 8'h02
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_en,
    input  logic       wrap,
    input  logic [7:0] in_data,
    input  logic       in_ctrl,
    output logic       armed,
    output logic       armed_low
);
    rx_state_t  state_q, state_d;
    logic [7:0] b1_q, cnt_q;
    logic       dir_q;
    logic       pair_down, pair_up;

    assign pair_down = (b1_q == 8'h00) && (in_data == DOWN_CODE);
    assign pair_up   = (b1_q == UP_CODE) && (in_data == 8'h00);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            R_HUNT:  if (sym_en && in_ctrl && in_data == Q_CODE) state_d = R_LANE1;
            R_LANE1: if (sym_en) state_d = in_ctrl ? R_HUNT : R_LANE2;
            R_LANE2: if (sym_en) state_d = (!in_ctrl && (pair_down || pair_up)) ? R_LANE3 : R_HUNT;
            R_LANE3: if (sym_en) state_d = (!in_ctrl && in_data >= MIN_COUNT) ? R_COUNT : R_HUNT;
            R_COUNT: if (sym_en && cnt_q == 8'd1) state_d = R_ARMED;
            R_ARMED: if (wrap) state_d = R_HUNT;
            default: state_d = R_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= R_HUNT;
            b1_q    <= 8'd0;
            cnt_q   <= 8'd0;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == R_LANE1 && sym_en) b1_q <= in_data;
            if (state_q == R_LANE2 && sym_en) dir_q <= pair_down;
            if (state_q == R_LANE3 && sym_en) cnt_q <= in_data;
            else if (state_q == R_COUNT && sym_en) cnt_q <= cnt_q - 8'd1;
        end
    end

    always_comb begin
        armed     = (state_q == R_ARMED);
        armed_low = dir_q;
    end

    // R8
    short_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == R_LANE3 && sym_en && in_data < MIN_COUNT) |=> (state_q == R_HUNT));

    // R8
    busy_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == R_COUNT && !sym_en) |=> (state_q == R_COUNT));
endmodule

// File: rtl/rate_shift_ctrl.sv
module rate_shift_ctrl #(
    parameter int         DIV_RATIO = 10,
    parameter int         COUNT_N   = 4,
    parameter logic [7:0] Q_CODE    = 8'h9C,
    parameter logic [7:0] IDLE_CODE = 8'h07,
    parameter logic [7:0] DOWN_CODE = 8'h01,
    parameter logic [7:0] UP_CODE   = 8'h02
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shift_req,
    input  logic       shift_dir,
    input  logic [7:0] tx_in_data,
    input  logic       tx_in_ctrl,
    output logic [7:0] tx_out_data,
    output logic       tx_out_ctrl,
    input  logic [7:0] rx_in_data,
    input  logic       rx_in_ctrl,
    output logic       speed_is_low,
    output logic       sym_en,
    output logic       rx_speed_is_low,
    output logic       rx_sym_en
);
    logic tx_wrap, tx_armed, tx_armed_low;
    logic rx_wrap, rx_armed, rx_armed_low;

    rsc_divider #(.DIV_RATIO(DIV_RATIO)) u_tx_div (
        .clk(clk), .rst_n(rst_n), .armed_i(tx_armed), .armed_low_i(tx_armed_low),
        .wrap_o(tx_wrap), .sym_en_o(sym_en), .low_o(speed_is_low)
    );

    rsc_tx_ctrl #(
        .Q_CODE(Q_CODE), .IDLE_CODE(IDLE_CODE), .DOWN_CODE(DOWN_CODE),
        .UP_CODE(UP_CODE), .COUNT_N(COUNT_N)
    ) u_tx (
        .clk(clk), .rst_n(rst_n), .sym_en(sym_en), .wrap(tx_wrap),
        .cur_low(speed_is_low), .shift_req(shift_req), .shift_dir(shift_dir),
        .in_data(tx_in_data), .in_ctrl(tx_in_ctrl),
        .out_data(tx_out_data), .out_ctrl(tx_out_ctrl),
        .armed(tx_armed), .armed_low(tx_armed_low)
    );

    rsc_divider #(.DIV_RATIO(DIV_RATIO)) u_rx_div (
        .clk(clk), .rst_n(rst_n), .armed_i(rx_armed), .armed_low_i(rx_armed_low),
        .wrap_o(rx_wrap), .sym_en_o(rx_sym_en), .low_o(rx_speed_is_low)
    );

    rsc_rx_ctrl #(
        .Q_CODE(Q_CODE), .DOWN_CODE(DOWN_CODE), .UP_CODE(UP_CODE)
    ) u_rx (
        .clk(clk), .rst_n(rst_n), .sym_en(rx_sym_en), .wrap(rx_wrap),
        .in_data(rx_in_data), .in_ctrl(rx_in_ctrl),
        .armed(rx_armed), .armed_low(rx_armed_low)
    );

    // R7
    rx_switch_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_speed_is_low != $past(rx_speed_is_low)) |-> $past(rx_armed));
endmodule

// File: tb/rate_shift_ctrl_bench.sv
`timescale 1ns/1ps
module rate_shift_ctrl_bench;
    localparam int         DIV   = 10;
    localparam int         NCNT  = 4;
    localparam logic [7:0] QC    = 8'h9C;
    localparam logic [7:0] IDLEC = 8'h07;
    localparam logic [7:0] DNC   = 8'h01;
    localparam logic [7:0] UPC   = 8'h02;

    logic clk = 1'b0, rst_n = 1'b0;
    logic shift_req = 1'b0, shift_dir = 1'b0;
    logic [7:0] tx_in_data = IDLEC, tx_out_data;
    logic tx_in_ctrl = 1'b1, tx_out_ctrl;
    logic speed_is_low, sym_en, rx_speed_is_low, rx_sym_en;

    always #5 clk = ~clk;

    rate_shift_ctrl u_rate_shift_ctrl (
        .clk(clk), .rst_n(rst_n), .shift_req(shift_req), .shift_dir(shift_dir),
        .tx_in_data(tx_in_data), .tx_in_ctrl(tx_in_ctrl),
        .tx_out_data(tx_out_data), .tx_out_ctrl(tx_out_ctrl),
        .rx_in_data(tx_out_data), .rx_in_ctrl(tx_out_ctrl),
        .speed_is_low(speed_is_low), .sym_en(sym_en),
        .rx_speed_is_low(rx_speed_is_low), .rx_sym_en(rx_sym_en)
    );

    int total = 0, bad = 0;
    bit mon_on = 0, done = 0;
    int k = 0;
    bit m_low = 0, m_counting = 0, m_armed = 0, m_dir = 0;
    int m_cnt = 0, ps = 0, os_seen = 0, bad_sent = 0;
    bit pdir = 0, last_dir = 0;
    logic [7:0] pb1;
    int seg_kind = 1, seg_len = 0, seg_pos = 0, bad_v = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (k=%0d)", tag, act, exp, k);
        end
    endtask

    function automatic bit exp_sym(input bit low, input int cyc);
        return !low || (cyc % DIV == 0);
    endfunction

    task automatic gen_next();
        if (seg_pos >= seg_len) begin
            if (seg_kind == 0) begin
                seg_kind = ($urandom % 4 == 0) ? 2 : 1;
                seg_len  = (seg_kind == 2) ? 16 : 8 + int'($urandom % 5);
                bad_v    = int'($urandom % 3);
            end else begin
                seg_kind = 0;
                seg_len  = 4 + int'($urandom % 9);
            end
            seg_pos = 0;
        end
        if (seg_kind == 0) begin
            tx_in_ctrl = 1'b0; tx_in_data = 8'($urandom);
        end else if (seg_kind == 2 && seg_pos >= 6 && seg_pos <= 9) begin
            tx_in_ctrl = (seg_pos == 6);
            case (seg_pos)
                6: tx_in_data = QC;
                7: tx_in_data = (bad_v == 2) ? UPC : 8'h00;
                8: tx_in_data = (bad_v == 0) ? 8'h05 : (bad_v == 1 ? DNC : UPC);
                default: begin tx_in_data = (bad_v == 1) ? 8'd2 : 8'd4; bad_sent++; end
            endcase
        end else begin
            tx_in_ctrl = 1'b1; tx_in_data = IDLEC;
        end
        seg_pos++;
    endtask

    // cycle-exact monitor and stream driver
    initial begin
        bit last_sym, arm_now;
        forever begin
            @(negedge clk);
            last_sym = 0;
            if (mon_on) begin
                arm_now = m_armed;
                chk(sym_en == exp_sym(m_low, k), "R2 R3 sym_en", sym_en, exp_sym(m_low, k));
                chk(speed_is_low == m_low, "R6 speed_is_low", speed_is_low, m_low);
                chk(rx_speed_is_low == m_low, "R8 rx_speed_is_low", rx_speed_is_low, m_low);
                chk(rx_sym_en == sym_en, "R7 rx_sym_en", rx_sym_en, sym_en);
                if ({tx_out_ctrl, tx_out_data} != {tx_in_ctrl, tx_in_data})
                    chk(tx_in_ctrl && tx_in_data == IDLEC, "R4 replaced non-idle",
                        {tx_in_ctrl, tx_in_data}, {1'b1, IDLEC});
                if (sym_en) begin
                    last_sym = 1;
                    if (m_counting) begin
                        m_cnt--;
                        if (m_cnt == 0) begin m_counting = 0; m_armed = 1; end
                    end else if (!m_armed) begin
                        case (ps)
                            0: if (tx_out_ctrl && tx_out_data == QC) ps = 1;
                            1: if (tx_out_ctrl) ps = 0; else begin pb1 = tx_out_data; ps = 2; end
                            2: begin
                                ps = 0;
                                if (!tx_out_ctrl && pb1 == 8'h00 && tx_out_data == DNC) begin pdir = 1; ps = 3; end
                                else if (!tx_out_ctrl && pb1 == UPC && tx_out_data == 8'h00) begin pdir = 0; ps = 3; end
                            end
                            default: begin
                                ps = 0;
                                if (!tx_out_ctrl && tx_out_data >= 8'd3) begin
                                    os_seen++; last_dir = pdir;
                                    chk(tx_out_data == 8'(NCNT), "R6 countdown byte", tx_out_data, NCNT);
                                    chk(pdir != m_low, "R10 set for new speed only", pdir, !m_low);
                                    m_cnt = tx_out_data; m_dir = pdir; m_counting = 1;
                                end
                            end
                        endcase
                    end
                end
                if (arm_now && (k % DIV == DIV - 1)) begin m_low = m_dir; m_armed = 0; end
                k++;
            end
            @(posedge clk); #1;
            if (last_sym) gen_next();
        end
    end

    task automatic pulse_req(input bit dir);
        @(posedge clk); #1; shift_req = 1; shift_dir = dir;
        @(posedge clk); #1; shift_req = 0;
    endtask

    task automatic wait_speed(input bit val);
        for (int i = 0; i < 4000 && m_low != val; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int base, pulses;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(speed_is_low == 0, "R1 speed_is_low in reset", speed_is_low, 0);
        chk(sym_en == 1, "R1 sym_en in reset", sym_en, 1);
        chk(rx_speed_is_low == 0 && rx_sym_en == 1, "R1 rx side in reset", rx_sym_en, 1);
        chk(tx_out_data == tx_in_data && tx_out_ctrl == tx_in_ctrl, "R1 passthrough", tx_out_data, tx_in_data);
        @(posedge clk); #1; rst_n = 1; mon_on = 1;
        repeat (50) @(negedge clk);

        // R10: request for current (full) speed is dropped
        base = os_seen;
        pulse_req(0);
        repeat (400) @(negedge clk);
        chk(os_seen == base, "R10 no set at full speed", os_seen, base);

        // R5 R6: down shift
        base = os_seen;
        pulse_req(1);
        wait_speed(1);
        chk(m_low == 1 && os_seen == base + 1, "R6 down shift done", os_seen, base + 1);
        chk(last_dir == 1, "R5 down set lanes", last_dir, 1);

        // R2: ten-cycle spacing at low rate
        pulses = 0;
        repeat (100) begin @(negedge clk); pulses += int'(sym_en); end
        chk(pulses == 10, "R2 pulses per 100 cycles", pulses, 10);

        // R10 at low speed
        base = os_seen;
        pulse_req(1);
        repeat (600) @(negedge clk);
        chk(os_seen == base, "R10 no set at low speed", os_seen, base);

        // R9: request during countdown is held
        base = os_seen;
        pulse_req(0);
        for (int i = 0; i < 4000 && os_seen == base; i++) @(negedge clk);
        chk(last_dir == 0, "R5 up set lanes", last_dir, 0);
        pulse_req(1);
        wait_speed(0);
        chk(m_low == 0, "R9 first shift completes", m_low, 0);
        wait_speed(1);
        chk(m_low == 1 && os_seen == base + 2, "R9 held shift executes", os_seen, base + 2);

        // random phase
        for (int n = 0; n < 120; n++) begin
            repeat (100 + int'($urandom % 300)) @(negedge clk);
            pulse_req(1'($urandom));
        end
        repeat (2000) @(negedge clk);
        chk(bad_sent > 0, "R8 malformed sets were sent", bad_sent, 1);
        chk(os_seen > 4, "R7 several shifts observed", os_seen, 5);
        finish_run();
    end
endmodule